// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a TLB miss. It takes a 32-bit virtual address, a write/read indication and the current table base register value. It then fetches descriptors from memory over a word-wide request/response port. Most of the address space is mapped by first-level 1 MB section descriptors. A few first-level entries instead point at a 1 KB second-level table of 256 entries, and each of those entries maps a 4 KB small page. When the walk ends, the block hands the TLB fill logic one of two things: a physical address with memory attributes, or a fault with the virtual address that caused it.

All descriptors belong to access domain zero under client rules, so the access-permission field inside each descriptor is always enforced. A region marked no-access reports a permission fault and never produces a translation. The returned attributes separate two kinds of memory. Normal memory is cacheable and may be executable. Device memory is uncached, non-executable and outer-shareable. Every table read carries a cacheability hint, taken from the region field of the table base register. Only write-back markings allow the read to be looked up in the data cache.

All three data paths are valid/ready. New walks enter on `req_*`. Descriptor reads leave on `mem_req_*`, and their data returns on `mem_rsp_*`. Results leave on `res_*`. A transfer takes place on a clock edge at which both valid and ready are high. A valid that is raised stays raised, with its payload unchanged, until it is accepted. The block raises `req_ready` only while idle. It raises `mem_rsp_ready` only while it waits for a descriptor. It holds a result on `res_*` until `res_ready` accepts it.

Top module: `tt_walker`

## Requirements
- R1: The first read of a walk goes to `{table_base[31:14], va[31:20], 2'b00}` and is presented on the clock after the walk request is accepted. Table base bits [13:0] do not affect the address.
- R2: A first-level descriptor with bits [1:0] = 10 is a section. The walk then makes exactly one read and returns `{desc[31:20], va[19:0]}` as the physical address.
- R3: A first-level descriptor with bits [1:0] = 01 points to a second-level table. The second read goes to `{desc[31:10], va[19:12], 2'b00}`. A second-level descriptor with bit 1 set is a small page, and the walk returns `{desc[31:12], va[11:0]}`.
- R4: A translation fault is reported in three cases: the first-level bits [1:0] are 00 or 11, or the second-level bits [1:0] are 00 or 01. The result has `res_xlat_fault` = 1, the physical address is 0, and `res_fault_va` is the walked address. A first-level fault makes only one read.
- R5: The permission field sits at bits [11:10] of a section and bits [5:4] of a small page. The value 00 denies every access. The value 01 denies writes only. The values 10 and 11 allow all accesses. A denied access reports `res_perm_fault` with the faulting address, a physical address of 0 and no translation.
- R6: Descriptor bit 3 set selects Normal memory: cacheable = 1, outer-shareable = 0, and executable = NOT execute-never. The execute-never bit is section bit 4 or page bit 0. Bit 3 clear selects Device memory: cacheable = 0, executable = 0, outer-shareable = 1. A faulting result has all attributes at 0.
- R7: `mem_req_cached` is 1 for every read of a walk whose table base bits [4:3] were 01 or 11 (write-back). It is 0 for 00 (uncached) and for 10 (write-through).
- R8: `req_ready` is high only when no walk is in progress. A result stays on `res_*`, unchanged, until `res_ready` takes it. On the next cycle `res_valid` is low and `req_ready` is high again.
- R9: A pending descriptor read holds its address until `mem_req_ready`. A response that arrives while `mem_rsp_ready` is low is ignored.
- R10: A result never has both fault flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and able to accept a walk |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| table_base | input | 32 | Table base register: [31:14] level-1 base, [4:3] table-read cacheability |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the descriptor |
| mem_req_cached | output | 1 | Read may be looked up in the data cache |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_ready | output | 1 | Walker waiting for descriptor data |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Walk result valid |
| res_ready | input | 1 | TLB fill accepts the result |
| res_pa | output | 32 | Physical address, 0 on a fault |
| res_cacheable | output | 1 | Normal cacheable memory |
| res_exec | output | 1 | Instruction fetch allowed |
| res_outer_share | output | 1 | Device outer-shareable memory |
| res_xlat_fault | output | 1 | Translation fault |
| res_perm_fault | output | 1 | Permission fault |
| res_fault_va | output | 32 | Faulting virtual address, 0 when no fault |

## Verification
The bench walks sections, pointers to second-level tables, and pages at the first and last slots of a table.

It exercises each access-permission code with both reads and writes. A design that skipped the write-only denial would translate writes to read-only pages. It also exercises the reserved descriptor encodings on both levels, where a decoder that treated the reserved first-level code as a pointer would issue a second read that should never happen.

It corrupts the request inputs and the table base while a walk is in progress. A design that did not capture them at acceptance would read the wrong table. It also applies each table-base region code. A design that honoured write-through would mark reads as cacheable.

Finally, it stalls the memory port and pushes junk responses while the read is still pending, and it delays `res_ready`. A design that took early data would return a wrong address. A design that dropped its result would lose the walk.

// File: rtl/tt_walker_pkg.sv
package tt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5
  } walk_state_e;

  typedef enum logic [1:0] {
    DK_FAULT = 2'd0,
    DK_TABLE = 2'd1,
    DK_LEAF  = 2'd2
  } desc_kind_e;

  typedef struct packed {
    logic cacheable;
    logic exec;
    logic outer_share;
  } mem_attr_t;

  localparam logic [1:0] AP_NONE   = 2'b00;
  localparam logic [1:0] AP_RDONLY = 2'b01;

  // Write-back region codes (01, 11) allow cached table reads.
  function automatic logic region_write_back(input logic [1:0] rgn);
    return rgn[0];
  endfunction

  function automatic mem_attr_t attr_from(input logic normal, input logic xn);
    mem_attr_t a;
    a.cacheable   = normal;
    a.exec        = normal & ~xn;
    a.outer_share = ~normal;
    return a;
  endfunction

  function automatic logic perm_denied(input logic [1:0] ap, input logic wr);
    return (ap == AP_NONE) || ((ap == AP_RDONLY) && wr);
  endfunction

endpackage

// File: rtl/tt_desc_decode.sv
module tt_desc_decode
  import tt_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter bit IS_L2    = 1'b0
) (
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  input  logic              wr,
  output desc_kind_e        kind,
  output logic [ADDR_W-1:0] leaf_pa,
  output mem_attr_t         attr,
  output logic              denied
);

  localparam int SECT_SHIFT = ADDR_W - L1_IDX_W;
  localparam int PAGE_SHIFT = SECT_SHIFT - L2_IDX_W;

  logic unused_bits;
  assign unused_bits = ^{desc, va};

  generate
    if (!IS_L2) begin : g_section
      always_comb begin
        unique case (desc[1:0])
          2'b10:   kind = DK_LEAF;
          2'b01:   kind = DK_TABLE;
          default: kind = DK_FAULT;
        endcase
        leaf_pa = {desc[ADDR_W-1:SECT_SHIFT], va[SECT_SHIFT-1:0]};
        attr    = attr_from(desc[3], desc[4]);
        denied  = perm_denied(desc[11:10], wr);
      end
    end else begin : g_page
      always_comb begin
        kind    = desc[1] ? DK_LEAF : DK_FAULT;
        leaf_pa = {desc[ADDR_W-1:PAGE_SHIFT], va[PAGE_SHIFT-1:0]};
        attr    = attr_from(desc[3], desc[0]);
        denied  = perm_denied(desc[5:4], wr);
      end
    end
  endgenerate

endmodule

// File: rtl/tt_walk_ctrl.sv
module tt_walk_ctrl
  import tt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        l1_is_table,
  input  logic        res_ready,
  output walk_state_e state
);

  walk_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:    if (req_valid)     state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_req_ready) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid) state_d = l1_is_table ? ST_L2_REQ : ST_DONE;
      ST_L2_REQ:  if (mem_req_ready) state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
      ST_DONE:    if (res_ready)     state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/tt_walker.sv
module tt_walker
  import tt_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_cached,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_pa,
  output logic              res_cacheable,
  output logic              res_exec,
  output logic              res_outer_share,
  output logic              res_xlat_fault,
  output logic              res_perm_fault,
  output logic [ADDR_W-1:0] res_fault_va
);

  localparam int SECT_SHIFT = ADDR_W - L1_IDX_W;
  localparam int PAGE_SHIFT = SECT_SHIFT - L2_IDX_W;
  localparam int TTB_ALIGN  = L1_IDX_W + 2;
  localparam int L2_ALIGN   = L2_IDX_W + 2;

  walk_state_e       state;
  logic [ADDR_W-1:0] va_q, addr_q, pa_q;
  logic              wr_q, cached_q, xf_q, pf_q;
  mem_attr_t         attr_q;

  desc_kind_e        l1_kind, l2_kind, sel_kind;
  logic [ADDR_W-1:0] l1_pa, l2_pa, sel_pa, l2_addr;
  mem_attr_t         l1_attr, l2_attr, sel_attr;
  logic              l1_denied, l2_denied, sel_denied;
  logic              take_l1, take_l2, finish;

  logic unused_tb;
  assign unused_tb = ^{table_base[TTB_ALIGN-1:5], table_base[2:0]};

  tt_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .l1_is_table   (l1_kind == DK_TABLE),
    .res_ready     (res_ready),
    .state         (state)
  );

  tt_desc_decode #(
    .ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .IS_L2(1'b0)
  ) u_dec_l1 (
    .desc    (mem_rsp_data),
    .va      (va_q),
    .wr      (wr_q),
    .kind    (l1_kind),
    .leaf_pa (l1_pa),
    .attr    (l1_attr),
    .denied  (l1_denied)
  );

  tt_desc_decode #(
    .ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .IS_L2(1'b1)
  ) u_dec_l2 (
    .desc    (mem_rsp_data),
    .va      (va_q),
    .wr      (wr_q),
    .kind    (l2_kind),
    .leaf_pa (l2_pa),
    .attr    (l2_attr),
    .denied  (l2_denied)
  );

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign mem_rsp_ready = (state == ST_L1_WAIT) || (state == ST_L2_WAIT);
  assign res_valid     = (state == ST_DONE);

  assign take_l1 = (state == ST_L1_WAIT) && mem_rsp_valid;
  assign take_l2 = (state == ST_L2_WAIT) && mem_rsp_valid;
  assign finish  = (take_l1 && (l1_kind != DK_TABLE)) || take_l2;

  assign l2_addr = {mem_rsp_data[ADDR_W-1:L2_ALIGN], va_q[SECT_SHIFT-1:PAGE_SHIFT], 2'b00};

  always_comb begin
    if (state == ST_L2_WAIT) begin
      sel_kind = l2_kind; sel_pa = l2_pa; sel_attr = l2_attr; sel_denied = l2_denied;
    end else begin
      sel_kind = l1_kind; sel_pa = l1_pa; sel_attr = l1_attr; sel_denied = l1_denied;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q     <= '0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      cached_q <= 1'b0;
      pa_q     <= '0;
      attr_q   <= '0;
      xf_q     <= 1'b0;
      pf_q     <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        va_q     <= req_va;
        wr_q     <= req_write;
        cached_q <= region_write_back(table_base[4:3]);
        addr_q   <= {table_base[ADDR_W-1:TTB_ALIGN], req_va[ADDR_W-1:SECT_SHIFT], 2'b00};
      end
      if (take_l1 && (l1_kind == DK_TABLE)) begin
        addr_q <= l2_addr;
      end
      if (finish) begin
        xf_q <= (sel_kind != DK_LEAF);
        pf_q <= (sel_kind == DK_LEAF) && sel_denied;
        if ((sel_kind == DK_LEAF) && !sel_denied) begin
          pa_q   <= sel_pa;
          attr_q <= sel_attr;
        end else begin
          pa_q   <= '0;
          attr_q <= '0;
        end
      end
    end
  end

  assign mem_req_addr    = addr_q;
  assign mem_req_cached  = cached_q;
  assign res_pa          = pa_q;
  assign res_cacheable   = attr_q.cacheable;
  assign res_exec        = attr_q.exec;
  assign res_outer_share = attr_q.outer_share;
  assign res_xlat_fault  = xf_q;
  assign res_perm_fault  = pf_q;
  assign res_fault_va    = (xf_q || pf_q) ? va_q : '0;

endmodule

// File: rtl/tt_walker_chk.sv
module tt_walker_chk #(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_va,
  input logic [ADDR_W-1:0] table_base,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_cached,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_pa,
  input logic              res_cacheable,
  input logic              res_exec,
  input logic              res_outer_share,
  input logic              res_xlat_fault,
  input logic              res_perm_fault
);

  localparam int SECT_SHIFT = ADDR_W - L1_IDX_W;
  localparam int TTB_ALIGN  = L1_IDX_W + 2;

  // R1
  l1_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req_valid &&
      mem_req_addr == {$past(table_base[ADDR_W-1:TTB_ALIGN]),
                       $past(req_va[ADDR_W-1:SECT_SHIFT]), 2'b00}));

  // R7
  walk_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req_cached == $past(table_base[3])));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) &&
      $stable(res_xlat_fault) && $stable(res_perm_fault)));

  // R8
  busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mem_req_valid) |-> !req_ready);

  // R8
  res_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid && req_ready));

  // R10
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_xlat_fault && res_perm_fault));

  // R6
  fault_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_xlat_fault || res_perm_fault)) |->
      (res_pa == '0 && !res_cacheable && !res_exec && !res_outer_share));

  // R6
  device_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_xlat_fault && !res_perm_fault && !res_cacheable) |->
      (!res_exec && res_outer_share));

endmodule

bind tt_walker tt_walker_chk #(.ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_va          (req_va),
  .table_base      (table_base),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .mem_req_cached  (mem_req_cached),
  .res_valid       (res_valid),
  .res_ready       (res_ready),
  .res_pa          (res_pa),
  .res_cacheable   (res_cacheable),
  .res_exec        (res_exec),
  .res_outer_share (res_outer_share),
  .res_xlat_fault  (res_xlat_fault),
  .res_perm_fault  (res_perm_fault)
);

// File: tb/tt_walker_tb.sv
module tt_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [31:0] table_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_req_cached;
  logic        mem_rsp_valid;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data;
  logic        res_valid;
  logic        res_ready;
  logic [31:0] res_pa;
  logic        res_cacheable, res_exec, res_outer_share;
  logic        res_xlat_fault, res_perm_fault;
  logic [31:0] res_fault_va;

  always #5 clk = ~clk;

  tt_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .table_base(table_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_cached(mem_req_cached),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
    .res_cacheable(res_cacheable), .res_exec(res_exec),
    .res_outer_share(res_outer_share), .res_xlat_fault(res_xlat_fault),
    .res_perm_fault(res_perm_fault), .res_fault_va(res_fault_va)
  );

  typedef struct {
    logic [31:0] pa;
    logic        c, x, s, xf, pf, cached;
    logic [31:0] fva, a1, a2;
    int          nreads;
    int          stall;
    string       tag;
  } exp_t;

  logic [31:0] tmem [logic [31:0]];
  exp_t        exp_q[$];
  logic [31:0] rd_log[$];
  logic        cached_log[$];
  int          n_checks = 0;
  int          n_fail = 0;
  int          stall_cfg = 0;
  int          stall_left = 0;
  int          hold_left = 0;
  bit          done = 0;

  localparam logic [31:0] TB0 = 32'h0001_0000;
  localparam logic [31:0] L2T = 32'h0002_0400;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return tmem.exists(a) ? tmem[a] : 32'h0;
  endfunction

  // Expected result computed from the requirement text
  function automatic exp_t model(input logic [31:0] va, input logic wr,
                                 input logic [31:0] tb, input int stall, input string tag);
    exp_t e;
    logic [31:0] d1, d2, d;
    logic [1:0] ap;
    logic xn, leaf;
    e.pa = 0; e.c = 0; e.x = 0; e.s = 0; e.xf = 0; e.pf = 0; e.fva = 0; e.a2 = 0;
    e.stall = stall; e.tag = tag;
    e.cached = (tb[4:3] == 2'b01) || (tb[4:3] == 2'b11);
    e.a1 = {tb[31:14], va[31:20], 2'b00};
    e.nreads = 1;
    d1 = rd(e.a1);
    leaf = 0; ap = 0; xn = 0; d = 0;
    if (d1[1:0] == 2'b10) begin
      leaf = 1; d = d1; ap = d1[11:10]; xn = d1[4];
      e.pa = {d1[31:20], va[19:0]};
    end else if (d1[1:0] == 2'b01) begin
      e.nreads = 2;
      e.a2 = {d1[31:10], va[19:12], 2'b00};
      d2 = rd(e.a2);
      if (d2[1]) begin
        leaf = 1; d = d2; ap = d2[5:4]; xn = d2[0];
        e.pa = {d2[31:12], va[11:0]};
      end
    end
    if (!leaf) begin
      e.xf = 1; e.fva = va; e.pa = 0;
    end else if (ap == 2'b00 || (ap == 2'b01 && wr)) begin
      e.pf = 1; e.fva = va; e.pa = 0;
    end else begin
      e.c = d[3]; e.x = d[3] & ~xn; e.s = ~d[3];
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic compare(input exp_t e);
    chk(e.tag, "pa", res_pa, e.pa);
    chk(e.tag, "xlat_fault", 32'(res_xlat_fault), 32'(e.xf));
    chk(e.tag, "perm_fault", 32'(res_perm_fault), 32'(e.pf));
    chk(e.tag, "fault_va", res_fault_va, e.fva);
    chk("R6", "cacheable", 32'(res_cacheable), 32'(e.c));
    chk("R6", "exec", 32'(res_exec), 32'(e.x));
    chk("R6", "outer_share", 32'(res_outer_share), 32'(e.s));
    chk("R10", "both faults", 32'(res_xlat_fault & res_perm_fault), 32'h0);
    chk((e.stall > 0) ? "R9" : e.tag, "read count", 32'(rd_log.size()), 32'(e.nreads));
    if (rd_log.size() > 0) chk("R1", "l1 addr", rd_log[0], e.a1);
    if (e.nreads == 2 && rd_log.size() > 1) chk("R3", "l2 addr", rd_log[1], e.a2);
    foreach (cached_log[i]) chk("R7", "cached", 32'(cached_log[i]), 32'(e.cached));
  endtask

  // Memory responder with optional stall and junk responses
  initial begin
    logic [31:0] addr_now;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_data = 0; mem_req_ready = 0;
      if (mem_req_valid) begin
        if (stall_left > 0) begin
          stall_left--;
          mem_rsp_valid = 1; mem_rsp_data = 32'hDEAD_BEEF;
        end else begin
          mem_req_ready = 1;
          addr_now = mem_req_addr;
          rd_log.push_back(mem_req_addr);
          cached_log.push_back(mem_req_cached);
          @(negedge clk);
          mem_req_ready = 0;
          repeat (stall_cfg) @(negedge clk);
          mem_rsp_valid = 1; mem_rsp_data = rd(addr_now);
          while (!mem_rsp_ready) @(negedge clk);
          stall_left = stall_cfg;
        end
      end
    end
  end

  // Scoreboard monitor: pops expected items as results appear
  initial begin
    exp_t e;
    res_ready = 0;
    forever begin
      @(negedge clk);
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          chk("R8", "unexpected result", 32'h1, 32'h0);
        end else begin
          e = exp_q[0];
          compare(e);
          if (hold_left > 0) begin
            res_ready = 0; hold_left--;
          end else begin
            res_ready = 1;
            @(negedge clk);
            res_ready = 0;
            chk("R8", "released", {30'b0, res_valid, req_ready}, 32'h1);
            void'(exp_q.pop_front());
          end
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic wr, input logic [31:0] tb,
                      input int hold, input int stall, input string tag);
    exp_q.push_back(model(va, wr, tb, stall, tag));
    rd_log.delete(); cached_log.delete();
    hold_left = hold; stall_cfg = stall; stall_left = stall;
    @(negedge clk);
    req_va = va; req_write = wr; table_base = tb; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_va = 32'hFFFF_FFFF; req_write = ~wr; table_base = ~tb;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // level-1 table
    tmem[TB0 + 32'h123*4] = 32'h0AB0_0C0A;
    tmem[TB0 + 32'h400*4] = 32'h4000_0C02;
    tmem[TB0 + 32'h005*4] = 32'h0050_0C1A;
    tmem[TB0 + 32'hC00*4] = 32'hC000_000A;
    tmem[TB0 + 32'h010*4] = 32'h0100_040A;
    tmem[TB0 + 32'hD01*4] = 32'hD010_0C0B;
    tmem[TB0 + 32'hFFF*4] = 32'hFFF0_0C0A;
    tmem[TB0 + 32'h001*4] = L2T | 32'h1;
    // level-2 table
    tmem[L2T + 32'h00*4] = 32'h1111_103A;
    tmem[L2T + 32'h01*4] = 32'h2222_203B;
    tmem[L2T + 32'h02*4] = 32'h3333_3032;
    tmem[L2T + 32'h04*4] = 32'h4444_400A;
    tmem[L2T + 32'h05*4] = 32'h5555_501A;
    tmem[L2T + 32'h06*4] = 32'h7777_7039;
    tmem[L2T + 32'hFF*4] = 32'h6666_6032;

    repeat (3) @(negedge clk);
    chk("R8", "reset req_ready", 32'(req_ready), 32'h1);
    chk("R8", "reset res_valid", 32'(res_valid), 32'h0);
    chk("R9", "reset mem_req_valid", 32'(mem_req_valid), 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R8", "idle after reset", {30'b0, req_ready, res_valid}, 32'h2);

    // R2 sections, R7 region codes
    walk(32'h1234_5678, 0, TB0,                 0, 0, "R2");
    walk(32'h4001_2345, 1, TB0 | 32'h18,        0, 0, "R2");
    walk(32'h0051_0000, 0, TB0 | 32'h08,        0, 0, "R2");
    walk(32'hFFF8_0004, 0, TB0 | 32'h10,        0, 0, "R2");
    walk(32'h1234_5678, 0, TB0 | 32'h3FE0,      0, 0, "R1");
    // R5 permissions on sections
    walk(32'hC000_1000, 0, TB0, 0, 0, "R5");
    walk(32'hC000_1000, 1, TB0, 0, 0, "R5");
    walk(32'h0100_0ABC, 0, TB0, 0, 0, "R5");
    walk(32'h0100_0ABC, 1, TB0, 0, 0, "R5");
    // R4 first-level faults
    walk(32'hD000_0000, 0, TB0, 0, 0, "R4");
    walk(32'hD01F_FFFC, 1, TB0, 0, 0, "R4");
    // R3 second-level pages
    walk(32'h0010_0123, 0, TB0 | 32'h2A0, 0, 0, "R3");
    walk(32'h0010_1FFF, 0, TB0,           0, 0, "R3");
    walk(32'h0010_2000, 1, TB0 | 32'h08,  0, 0, "R3");
    walk(32'h001F_F777, 0, TB0,           0, 0, "R3");
    walk(32'h0010_3000, 0, TB0,           0, 0, "R4");
    walk(32'h0010_6010, 0, TB0,           0, 0, "R4");
    walk(32'h0010_4000, 0, TB0,           0, 0, "R5");
    walk(32'h0010_5008, 0, TB0,           0, 0, "R3");
    walk(32'h0010_5008, 1, TB0,           0, 0, "R5");
    // R8 result back-pressure, R9 memory stalls with junk responses
    walk(32'h1234_5678, 1, TB0,           2, 3, "R8");
    walk(32'h0010_0456, 0, TB0 | 32'h18,  3, 2, "R8");
    walk(32'hD000_0040, 0, TB0,           1, 4, "R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule